// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control front end of a successive-approximation ADC. It chooses where each start-of-conversion comes from, picks the analog input channel, makes a function-clock tick from the bus clock, and runs a request/done handshake with the converter. Each finished conversion is presented on a valid/ready result stream as a 10-bit sample tagged with its 4-bit channel number. A sticky done flag records that a capture happened.

A two-bit source mode selects the start source. `00` uses a software start pulse. `01` uses a baseband signal-strength request, which launches the sample after a programmable number of function-clock ticks. `10` is streaming: conversions run back to back for as long as `stream_en` is high. `11` uses an external timer trigger. In timer mode the channel can step round-robin through a list of eight 4-bit slots. In every other case the channel comes from slot 0.

Back-pressure rule: a captured result is held on `res_data`/`res_chan`, with `res_valid` high, until a cycle in which `res_ready` is high. While a result waits, and while a conversion is in flight, the block is busy. Start requests that arrive while it is busy are dropped, not queued. A stalled consumer therefore throttles the converter rather than losing samples.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The start source follows `mode_sel`: `00` uses `sw_start`, `01` uses the delayed `rssi_req`, `10` uses the `stream_en` level, and `11` uses `tmr_trig`. Start inputs that belong to other modes cause no conversion.
- R2: Slot k of `slot_list` occupies bits 4k+3:4k. When automatic stepping is inactive, every conversion uses slot 0 (bits 3:0).
- R3: Automatic stepping is active only when `auto_sw_en` is 1 and `mode_sel` is `11`. Successive conversions then use slots 0, 1, ... up to the slot index given by `auto_last`, and then wrap to slot 0.
- R4: Whenever automatic stepping is inactive, the slot pointer returns to slot 0, so the next automatic sequence starts at slot 0.
- R5: In mode `01`, a conversion launches on the clock edge after `rssi_delay` function-clock ticks have elapsed following the request (delay 0 launches on the next edge). A request that arrives while a delay is already counting is ignored.
- R6: `fclk_tick` is high for one bus cycle in every `clk_div`+1 cycles. With `clk_div` = 0 it is high every cycle.
- R7: `conv_req` rises on the edge that accepts a start and stays high until the edge that samples `conv_done`. `conv_chan` is stable for the whole time `conv_req` is high.
- R8: On `conv_done`, `conv_data` and the channel are captured and `res_valid` rises. `res_valid`, `res_data` and `res_chan` hold steady until accepted with `res_ready`.
- R9: A start request made while a conversion is in progress, or while a result is waiting, is ignored and is not queued.
- R10: `done_flag` is set by every capture and cleared by a `flag_clr` pulse. A capture in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Start-source mode |
| sw_start | input | 1 | Software start pulse (mode 00) |
| rssi_req | input | 1 | Signal-strength sample request (mode 01) |
| rssi_delay | input | 6 | Launch delay in function-clock ticks |
| stream_en | input | 1 | Continuous conversion enable (mode 10) |
| tmr_trig | input | 1 | Timer trigger pulse (mode 11) |
| auto_sw_en | input | 1 | Enables round-robin slot stepping |
| auto_last | input | 3 | Index of the last slot in the round-robin |
| slot_list | input | 32 | Eight 4-bit channel slots |
| clk_div | input | 10 | Function-clock divider minus one |
| fclk_tick | output | 1 | Function-clock enable tick |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | 4 | Channel select to the converter |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | 10 | Converter result |
| res_valid | output | 1 | Result stream valid |
| res_ready | input | 1 | Result stream ready |
| res_data | output | 10 | Captured result |
| res_chan | output | 4 | Channel of the captured result |
| done_flag | output | 1 | Sticky capture flag |
| flag_clr | input | 1 | Clears `done_flag` |

## Verification
A wrong slot pointer shows up in the channel tag of the very next result in timer mode. A missed wrap or reset shows up after at most eight conversions. A miscounting delay counter shifts the rise of `conv_req` relative to the visible `fclk_tick` pulses, so a delay error is measurable to the exact cycle on the first request. A corrupt handshake state shows up within one conversion as either an extra result that nothing expected or a dropped one, and the scoreboard reports both.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SRC_SOFT   = 2'b00,
    SRC_RSSI   = 2'b01,
    SRC_STREAM = 2'b10,
    SRC_TIMER  = 2'b11
  } src_mode_e;

  typedef enum logic [1:0] {
    CV_IDLE = 2'b00,
    CV_BUSY = 2'b01,
    CV_HOLD = 2'b10
  } cv_state_e;

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));

endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_seq_pkg::*;
#(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             sw_start_i,
  input  logic             rssi_req_i,
  input  logic [DLY_W-1:0] rssi_dly_i,
  input  logic             stream_en_i,
  input  logic             tmr_trig_i,
  input  logic             tick_i,
  output logic             start_req_o
);

  logic             armed_q;
  logic [DLY_W-1:0] wait_q;
  logic             rssi_fire;
  logic             rssi_mode;

  assign rssi_mode = (mode_i == SRC_RSSI);
  assign rssi_fire = rssi_mode && armed_q && (wait_q >= rssi_dly_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      wait_q  <= '0;
    end else if (!rssi_mode) begin
      armed_q <= 1'b0;
      wait_q  <= '0;
    end else if (armed_q) begin
      if (wait_q >= rssi_dly_i) begin
        armed_q <= 1'b0;
      end else if (tick_i) begin
        wait_q <= wait_q + 1'b1;
      end
    end else if (rssi_req_i) begin
      armed_q <= 1'b1;
      wait_q  <= '0;
    end
  end

  always_comb begin
    unique case (mode_i)
      SRC_SOFT:   start_req_o = sw_start_i;
      SRC_RSSI:   start_req_o = rssi_fire;
      SRC_STREAM: start_req_o = stream_en_i;
      default:    start_req_o = tmr_trig_i;
    endcase
  end

  // R5
  rssi_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !rssi_mode) |=> !armed_q);

  // R5
  rssi_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rssi_fire |=> !armed_q);

endmodule

// File: rtl/adc_chan_ptr.sv
module adc_chan_ptr #(
  parameter int SLOTS  = 8,
  parameter int CHAN_W = 4,
  localparam int PTR_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int LIST_W = SLOTS * CHAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_act_i,
  input  logic [PTR_W-1:0]  last_i,
  input  logic              advance_i,
  input  logic [LIST_W-1:0] list_i,
  output logic [CHAN_W-1:0] chan_o
);

  logic [CHAN_W-1:0] slot_arr [SLOTS];
  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  pick;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_arr[g] = list_i[g*CHAN_W +: CHAN_W];
  end

  assign pick   = auto_act_i ? ptr_q : '0;
  assign chan_o = slot_arr[pick];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (!auto_act_i) begin
      ptr_q <= '0;
    end else if (advance_i) begin
      if (ptr_q >= last_i) ptr_q <= '0;
      else                 ptr_q <= ptr_q + 1'b1;
    end
  end

  // R4
  ptr_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_act_i |=> (ptr_q == '0));

  // R3
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_act_i && advance_i && ptr_q >= last_i) |=> (ptr_q == '0));

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req_i,
  input  logic [CHAN_W-1:0] chan_i,
  output logic              launch_o,
  output logic              conv_req_o,
  output logic [CHAN_W-1:0] conv_chan_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [DATA_W-1:0] res_data_o,
  output logic [CHAN_W-1:0] res_chan_o,
  output logic              done_flag_o,
  input  logic              flag_clr_i
);

  cv_state_e         state_q;
  logic [CHAN_W-1:0] chan_q;
  logic [DATA_W-1:0] data_q;
  logic              flag_q;
  logic              capture;

  assign launch_o = (state_q == CV_IDLE) && start_req_i;
  assign capture  = (state_q == CV_BUSY) && conv_done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CV_IDLE;
      chan_q  <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        CV_IDLE: if (start_req_i) begin
          state_q <= CV_BUSY;
          chan_q  <= chan_i;
        end
        CV_BUSY: if (conv_done_i) begin
          state_q <= CV_HOLD;
          data_q  <= conv_data_i;
        end
        CV_HOLD: if (res_ready_i) begin
          state_q <= CV_IDLE;
        end
        default: state_q <= CV_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (capture)    flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign conv_req_o  = (state_q == CV_BUSY);
  assign conv_chan_o = chan_q;
  assign res_valid_o = (state_q == CV_HOLD);
  assign res_data_o  = data_q;
  assign res_chan_o  = chan_q;
  assign done_flag_o = flag_q;

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_o && !conv_done_i) |=> (conv_req_o && $stable(conv_chan_o)));

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=>
      (res_valid_o && $stable(res_data_o) && $stable(res_chan_o)));

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=> !conv_req_o);

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_o && conv_done_i) |=> done_flag_o);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CHAN_W = 4,
  parameter int SLOTS  = 8,
  parameter int DIV_W  = 10,
  parameter int DLY_W  = 6,
  localparam int PTR_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int LIST_W = SLOTS * CHAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              sw_start,
  input  logic              rssi_req,
  input  logic [DLY_W-1:0]  rssi_delay,
  input  logic              stream_en,
  input  logic              tmr_trig,
  input  logic              auto_sw_en,
  input  logic [PTR_W-1:0]  auto_last,
  input  logic [LIST_W-1:0] slot_list,
  input  logic [DIV_W-1:0]  clk_div,
  output logic              fclk_tick,
  output logic              conv_req,
  output logic [CHAN_W-1:0] conv_chan,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic [CHAN_W-1:0] res_chan,
  output logic              done_flag,
  input  logic              flag_clr
);

  logic              start_req;
  logic              launch;
  logic              auto_act;
  logic [CHAN_W-1:0] next_chan;

  assign auto_act = auto_sw_en && (mode_sel == SRC_TIMER);

  adc_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_i  (clk_div),
    .tick_o (fclk_tick)
  );

  adc_trig_sel #(.DLY_W(DLY_W)) u_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_sel),
    .sw_start_i  (sw_start),
    .rssi_req_i  (rssi_req),
    .rssi_dly_i  (rssi_delay),
    .stream_en_i (stream_en),
    .tmr_trig_i  (tmr_trig),
    .tick_i      (fclk_tick),
    .start_req_o (start_req)
  );

  adc_chan_ptr #(.SLOTS(SLOTS), .CHAN_W(CHAN_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_act_i (auto_act),
    .last_i     (auto_last),
    .advance_i  (launch),
    .list_i     (slot_list),
    .chan_o     (next_chan)
  );

  adc_conv_ctrl #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_conv (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req_i (start_req),
    .chan_i      (next_chan),
    .launch_o    (launch),
    .conv_req_o  (conv_req),
    .conv_chan_o (conv_chan),
    .conv_done_i (conv_done),
    .conv_data_i (conv_data),
    .res_valid_o (res_valid),
    .res_ready_i (res_ready),
    .res_data_o  (res_data),
    .res_chan_o  (res_chan),
    .done_flag_o (done_flag),
    .flag_clr_i  (flag_clr)
  );

  // R2
  fixed_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !auto_act) |=> (conv_chan == $past(slot_list[CHAN_W-1:0])));

endmodule

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic        sw_start = 1'b0, rssi_req = 1'b0, stream_en = 1'b0, tmr_trig = 1'b0;
  logic [5:0]  rssi_delay = '0;
  logic        auto_sw_en = 1'b0;
  logic [2:0]  auto_last = '0;
  logic [31:0] slot_list = 32'h76543210;
  logic [9:0]  clk_div = '0;
  logic        fclk_tick, conv_req, conv_done, res_valid, res_ready, done_flag, flag_clr;
  logic [3:0]  conv_chan, res_chan;
  logic [9:0]  conv_data, res_data;

  int checks = 0, errors = 0, launches = 0, exp_launch = 0, lat = 0, seq_m = 0, seq_e = 0;
  bit finished = 1'b0;
  bit prev_req = 1'b0;
  bit tk [0:1023];
  logic [3:0] exp_q [$];

  always #2.5 clk = ~clk;

  adc_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sw_start(sw_start),
    .rssi_req(rssi_req), .rssi_delay(rssi_delay), .stream_en(stream_en),
    .tmr_trig(tmr_trig), .auto_sw_en(auto_sw_en), .auto_last(auto_last),
    .slot_list(slot_list), .clk_div(clk_div), .fclk_tick(fclk_tick),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_data(conv_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_chan(res_chan), .done_flag(done_flag),
    .flag_clr(flag_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: done three cycles after the request, data = {chan, sequence}
  always @(negedge clk) begin
    if (!rst_n) begin
      conv_done <= 1'b0; conv_data <= '0; lat = 0; seq_m = 0;
    end else begin
      conv_done <= 1'b0;
      if (conv_req && !conv_done) begin
        if (lat == 2) begin
          conv_done <= 1'b1;
          conv_data <= {conv_chan, 6'(seq_m)};
          seq_m++;
          lat = 0;
        end else lat++;
      end
    end
  end

  // launch counter and scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_req && !prev_req) launches++;
      prev_req = conv_req;
      if (res_valid && res_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected result", int'(res_chan), -1);
        end else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          chk(res_chan == e, "R2/R3 result channel", int'(res_chan), int'(e));
          chk(res_data == {e, 6'(seq_e)}, "R8 result data", int'(res_data), int'({e, 6'(seq_e)}));
          seq_e++;
        end
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (conv_req || res_valid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: sw_start = 1'b1;
      1: rssi_req = 1'b1;
      2: tmr_trig = 1'b1;
      default: flag_clr = 1'b1;
    endcase
    @(negedge clk);
    sw_start = 1'b0; rssi_req = 1'b0; tmr_trig = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic drive_conv(input int which, input logic [3:0] ch);
    exp_q.push_back(ch);
    exp_launch++;
    pulse(which);
    wait_idle();
  endtask

  task automatic rssi_case(input int dly);
    int j, k, s1, s2;
    wait_idle();
    rssi_delay = 6'(dly);
    exp_q.push_back(slot_list[3:0]);
    exp_launch++;
    @(negedge clk); rssi_req = 1'b1;
    @(negedge clk); rssi_req = 1'b0;
    j = 1;
    while (!conv_req && j < 1000) begin
      tk[j] = fclk_tick; j++; @(negedge clk);
    end
    k = j - 1; s1 = 0; s2 = 0;
    for (int i = 1; i <= k - 1; i++) s1 += int'(tk[i]);
    for (int i = 1; i <= k - 2; i++) s2 += int'(tk[i]);
    chk(s1 == dly, "R5 ticks before launch", s1, dly);
    if (dly == 0) chk(k == 1, "R5 zero delay launch cycle", k, 1);
    else          chk(s2 == dly - 1, "R5 launch right after last tick", s2, dly - 1);
    wait_idle();
  endtask

  initial begin
    res_ready = 1'b1; flag_clr = 1'b0;
    repeat (4) @(negedge clk);
    chk(!conv_req && !res_valid, "R7 reset idle", int'(conv_req), 0);
    chk(!done_flag, "R10 reset flag", int'(done_flag), 0);
    rst_n = 1'b1;

    // R6 divider
    repeat (3) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      chk(fclk_tick, "R6 div 0 tick every cycle", int'(fclk_tick), 1);
      @(negedge clk);
    end
    clk_div = 10'd4;
    repeat (12) @(negedge clk);
    begin
      int last = -1, gap_bad = 0, cnt = 0;
      for (int i = 0; i < 25; i++) begin
        if (fclk_tick) begin
          if (last >= 0 && i - last != 5) gap_bad++;
          last = i; cnt++;
        end
        @(negedge clk);
      end
      chk(gap_bad == 0 && cnt == 5, "R6 div 4 period", cnt, 5);
    end

    // R1/R2 software mode, slot 0 even with auto enabled
    slot_list = 32'h7654321C; auto_sw_en = 1'b1; mode_sel = 2'b00;
    drive_conv(0, 4'hC);
    chk(done_flag, "R10 flag set on capture", int'(done_flag), 1);
    pulse(3);
    @(negedge clk);
    chk(!done_flag, "R10 flag cleared", int'(done_flag), 0);
    drive_conv(0, 4'hC);
    pulse(2); pulse(1); wait_idle();
    chk(launches == exp_launch, "R1 foreign starts ignored in mode 00", launches, exp_launch);

    // R9 start during conversion is dropped
    exp_q.push_back(4'hC); exp_launch++;
    pulse(0); @(negedge clk); sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
    wait_idle();
    chk(launches == exp_launch, "R9 busy start ignored", launches, exp_launch);

    // R8/R9 back-pressure
    res_ready = 1'b0;
    exp_q.push_back(4'hC); exp_launch++;
    pulse(0);
    while (!res_valid) @(negedge clk);
    pulse(0);
    repeat (4) @(negedge clk);
    chk(res_valid && res_chan == 4'hC, "R8 result held under back-pressure", int'(res_valid), 1);
    res_ready = 1'b1;
    wait_idle();
    chk(launches == exp_launch, "R9 start during hold ignored", launches, exp_launch);

    // R3/R4 timer round-robin
    slot_list = 32'h7654BA98; mode_sel = 2'b11; auto_last = 3'd2; auto_sw_en = 1'b1;
    drive_conv(2, 4'h8); drive_conv(2, 4'h9); drive_conv(2, 4'hA);
    drive_conv(2, 4'h8); drive_conv(2, 4'h9);
    pulse(0); wait_idle();
    chk(launches == exp_launch, "R1 software start ignored in mode 11", launches, exp_launch);
    @(negedge clk); auto_sw_en = 1'b0; @(negedge clk); auto_sw_en = 1'b1;
    drive_conv(2, 4'h8);
    auto_last = 3'd7;
    drive_conv(2, 4'h9);
    for (int i = 2; i < 8; i++) drive_conv(2, slot_list[i*4 +: 4]);
    drive_conv(2, 4'h8);
    @(negedge clk); mode_sel = 2'b00; @(negedge clk); mode_sel = 2'b11;
    drive_conv(2, 4'h8);
    auto_sw_en = 1'b0;
    drive_conv(2, 4'h8); drive_conv(2, 4'h8);

    // R5 delayed signal-strength launch
    mode_sel = 2'b01; clk_div = 10'd3;
    rssi_case(5);
    rssi_case(0);
    clk_div = 10'd1;
    rssi_case(63);
    chk(launches == exp_launch, "R5 launches", launches, exp_launch);

    // R1 streaming mode
    wait_idle();
    mode_sel = 2'b10; auto_sw_en = 1'b1;
    begin
      int base;
      base = launches;
      for (int i = 0; i < 4; i++) begin exp_q.push_back(4'h8); exp_launch++; end
      @(negedge clk); stream_en = 1'b1;
      while (launches < base + 4) @(negedge clk);
      stream_en = 1'b0;
    end
    wait_idle();
    chk(launches == exp_launch, "R1 streaming launches", launches, exp_launch);
    chk(exp_q.size() == 0, "R8 all results delivered", exp_q.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule